// File: doc/BRIEF.md
# Vector Register Group Legality Checker

This block sits beside a vector instruction decoder and decides, in the same cycle, whether an instruction's register operands form legal register groups. Its inputs are the three register numbers (destination, second source, first source), whether the first source is a vector register, whether the operation is masked, the group multiplier, the element width, the widest supported element, the segment field count and an operation class. It raises one illegal flag, plus one flag per rule so that a failing rule can be seen on its own.

Each operation class applies its own mix of rules. The rules cover group alignment, where a group of N registers must start at a multiple of N. They also cover limits on the multiplier and element width for double-width operations, a ban on masked writes to register 0, overlap between destination and source groups, and the register budget of segment accesses. Rules that do not belong to the selected class always pass. The block holds no state.

Top module: `vgrp_legality_check`

## Requirements
- R1: `illegal` is high exactly when at least one bit of `rule_fail` is high. Every rule that the selected class does not use reads 0. Class codes on `op_class`: 0 single-width, 1 widening with single-width sources, 2 widening with one wide source (wide second source), 3 narrowing, 4 mask-producing compare or carry, 5 reduction, 6 widening reduction, 7 load, store or merge.
- R2: Classes 1, 2, 3 and 6 fail bit 0 when the group size is 8, where the size is L = 1 << `lmul_log2`. They fail bit 1 when twice the element width exceeds the widest element, which is the case when `sew_code` >= `elen_code`. Width codes are 0=8, 1=16, 2=32 and 3=64 bits. No other class ever sets bits 0 or 1.
- R3: Class 0 with L > 1 fails bit 2 if the destination is not a multiple of L, and bit 3 if the second source is not. It fails bit 4 if a vector first source is not a multiple of L. It fails bit 5 if the operation is masked and the destination is register 0. With L = 1 the class always passes.
- R4: Class 1 fails bit 2 if the destination is not a multiple of 2L, and bit 5 when masked with destination 0, at any L. It fails bit 3 (bit 4) if the second (vector first) source is not a multiple of L. It fails bit 6 (bit 7) if the destination group of 2L registers overlaps the second (vector first) source group of L registers.
- R5: Class 2 fails bit 2 if the destination is not a multiple of 2L, and bit 5 when masked with destination 0. It fails bit 3 if the second source is not a multiple of 2L. A vector first source fails bit 4 if it is not a multiple of L, and bit 7 if its L-register group overlaps the 2L-register destination group. Bit 6 is never set.
- R6: Class 3 fails bit 3 if the second source is not a multiple of 2L, and bit 2 if the destination is not a multiple of L. It fails bit 6 if the L-register destination group overlaps the 2L-register second source group. It fails bit 5 when masked with destination 0 and L > 1, and bit 4 if a vector first source is not a multiple of L.
- R7: Class 4 checks only when L > 1. It fails bit 6 (bit 7) if the single destination register lies inside the second (vector first) source group of L registers. It fails bit 3 (bit 4) if that source is not a multiple of L. With L = 1 the class always passes, and bits 2 and 5 are never set.
- R8: Classes 5 and 6 fail bit 3 when the second source is not a multiple of L, and set no alignment, overlap, mask or segment bit other than that one.
- R9: Class 7 with L > 1 fails bit 2 if the destination is not a multiple of L, and bit 5 if masked with destination 0. It fails bit 8 when (`seg_fields` + 1) * L exceeds 8 registers, at any L.
- R10: Groups starting at a and b with sizes sa and sb overlap when a < b + sb and b < a + sa. Checks on the first source, both alignment and overlap, apply only while `src1_is_vec` is high.
- R11: Bit order of `rule_fail`: 0 multiplier limit, 1 width limit, 2 destination alignment, 3 second source alignment, 4 first source alignment, 5 masked write to register 0, 6 destination/second source overlap, 7 destination/first source overlap, 8 segment budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_reg | input | 5 | Destination register number |
| src2_reg | input | 5 | Second source register number |
| src1_reg | input | 5 | First source register number |
| src1_is_vec | input | 1 | First source is a vector register |
| masked | input | 1 | Operation is masked by register 0 |
| lmul_log2 | input | 2 | Group size as log2 (0..3 for 1..8) |
| sew_code | input | 2 | Element width code |
| elen_code | input | 2 | Widest supported element code |
| seg_fields | input | 3 | Segment field count minus one |
| op_class | input | 3 | Operation class code |
| illegal | output | 1 | Instruction operands are illegal |
| rule_fail | output | 9 | One flag per failing rule |

## Verification
The main sweep drives every class at every group size with every pair of destination and second source numbers. The first source, its vector flag, the mask bit, the width codes and the field count are derived from the pair, so all of them cover their ranges as well. This separates alignment faults, which depend on the low bits of a single register number, from overlap faults, which depend on the distance between two numbers. Dedicated tests then walk all width and multiplier combinations for the limit rules, and all field counts for the segment budget. Hand-picked corners pin down the behaviour at group size 1, where class 4 and class 0 must pass. They also cover partial overlap at the top of a destination group, and widening at group size 8, where a destination group of 16 would run past the register file.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;
  localparam int REG_W     = 5;
  localparam int LMUL_W    = 2;
  localparam int WCODE_W   = 2;
  localparam int NF_W      = 3;
  localparam int SPAN_W    = 6;
  localparam int END_W     = SPAN_W + 1;
  localparam int SEG_LIMIT = 8;
  localparam int LMUL_MAX_WIDE = 2;   // log2 of the largest multiplier a double-width class may use
  localparam int NOPS      = 3;       // destination, second source, first source

  localparam int RULE_LMUL  = 0;
  localparam int RULE_WIDTH = 1;
  localparam int RULE_DALN  = 2;
  localparam int RULE_S2ALN = 3;
  localparam int RULE_S1ALN = 4;
  localparam int RULE_V0    = 5;
  localparam int RULE_OV2   = 6;
  localparam int RULE_OV1   = 7;
  localparam int RULE_SEG   = 8;
  localparam int NRULES     = 9;

  typedef enum logic [2:0] {
    OPC_SINGLE   = 3'd0,
    OPC_WIDE_SS  = 3'd1,
    OPC_WIDE_WS  = 3'd2,
    OPC_NARROW   = 3'd3,
    OPC_MASK     = 3'd4,
    OPC_RED      = 3'd5,
    OPC_RED_WIDE = 3'd6,
    OPC_MEM      = 3'd7
  } opclass_e;

  // size of a register group relative to the multiplier
  typedef enum logic [1:0] {
    GSZ_NONE = 2'd0,
    GSZ_ONE  = 2'd1,
    GSZ_L    = 2'd2,
    GSZ_2L   = 2'd3
  } gsz_e;

  typedef enum logic [1:0] {
    V0_OFF    = 2'd0,
    V0_ALWAYS = 2'd1,
    V0_MULTI  = 2'd2
  } v0mode_e;

  typedef struct packed {
    logic    chk_limits;
    gsz_e    dst_al;
    gsz_e    src2_al;
    gsz_e    src1_al;
    v0mode_e v0;
    gsz_e    ovl_dst;
    gsz_e    ovl_src2;
    gsz_e    ovl_src1;
    logic    gate_multi;
    logic    chk_seg;
  } rule_plan_t;

  function automatic logic [SPAN_W-1:0] grp_span(gsz_e sz, logic [LMUL_W-1:0] lm);
    case (sz)
      GSZ_ONE: return SPAN_W'(1);
      GSZ_L:   return SPAN_W'(1) << lm;
      GSZ_2L:  return SPAN_W'(2) << lm;
      default: return '0;
    endcase
  endfunction

  function automatic logic grp_misaligned(logic [REG_W-1:0] r, logic [SPAN_W-1:0] span);
    if (span == '0) return 1'b0;
    return ((SPAN_W'(r)) & (span - SPAN_W'(1))) != '0;
  endfunction

  function automatic logic grp_overlap(logic [REG_W-1:0] a, logic [SPAN_W-1:0] sa,
                                       logic [REG_W-1:0] b, logic [SPAN_W-1:0] sb);
    logic [END_W-1:0] a_end;
    logic [END_W-1:0] b_end;
    a_end = END_W'(a) + END_W'(sa);
    b_end = END_W'(b) + END_W'(sb);
    if (sa == '0 || sb == '0) return 1'b0;
    return (END_W'(a) < b_end) && (END_W'(b) < a_end);
  endfunction

  function automatic logic seg_overflow(logic [NF_W-1:0] nf, logic [LMUL_W-1:0] lm);
    logic [END_W-1:0] regs;
    regs = END_W'(END_W'(nf) + END_W'(1)) << lm;
    return regs > END_W'(SEG_LIMIT);
  endfunction
endpackage

// File: rtl/vgrp_class_plan.sv
module vgrp_class_plan
  import vgrp_pkg::*;
(
  input  opclass_e   cls,
  output rule_plan_t plan
);
  always_comb begin
    plan = '{chk_limits: 1'b0, dst_al: GSZ_NONE, src2_al: GSZ_NONE, src1_al: GSZ_NONE,
             v0: V0_OFF, ovl_dst: GSZ_NONE, ovl_src2: GSZ_NONE, ovl_src1: GSZ_NONE,
             gate_multi: 1'b0, chk_seg: 1'b0};
    case (cls)
      OPC_SINGLE: begin
        plan.dst_al     = GSZ_L;
        plan.src2_al    = GSZ_L;
        plan.src1_al    = GSZ_L;
        plan.v0         = V0_MULTI;
        plan.gate_multi = 1'b1;
      end
      OPC_WIDE_SS: begin
        plan.chk_limits = 1'b1;
        plan.dst_al     = GSZ_2L;
        plan.src2_al    = GSZ_L;
        plan.src1_al    = GSZ_L;
        plan.v0         = V0_ALWAYS;
        plan.ovl_dst    = GSZ_2L;
        plan.ovl_src2   = GSZ_L;
        plan.ovl_src1   = GSZ_L;
      end
      OPC_WIDE_WS: begin
        plan.chk_limits = 1'b1;
        plan.dst_al     = GSZ_2L;
        plan.src2_al    = GSZ_2L;
        plan.src1_al    = GSZ_L;
        plan.v0         = V0_ALWAYS;
        plan.ovl_dst    = GSZ_2L;
        plan.ovl_src1   = GSZ_L;
      end
      OPC_NARROW: begin
        plan.chk_limits = 1'b1;
        plan.dst_al     = GSZ_L;
        plan.src2_al    = GSZ_2L;
        plan.src1_al    = GSZ_L;
        plan.v0         = V0_MULTI;
        plan.ovl_dst    = GSZ_L;
        plan.ovl_src2   = GSZ_2L;
      end
      OPC_MASK: begin
        plan.src2_al    = GSZ_L;
        plan.src1_al    = GSZ_L;
        plan.ovl_dst    = GSZ_ONE;
        plan.ovl_src2   = GSZ_L;
        plan.ovl_src1   = GSZ_L;
        plan.gate_multi = 1'b1;
      end
      OPC_RED: begin
        plan.src2_al    = GSZ_L;
      end
      OPC_RED_WIDE: begin
        plan.chk_limits = 1'b1;
        plan.src2_al    = GSZ_L;
      end
      OPC_MEM: begin
        plan.dst_al     = GSZ_L;
        plan.v0         = V0_MULTI;
        plan.gate_multi = 1'b1;
        plan.chk_seg    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vgrp_overlap_unit.sv
module vgrp_overlap_unit
  import vgrp_pkg::*;
(
  input  logic              enable,
  input  logic [REG_W-1:0]  base_a,
  input  logic [SPAN_W-1:0] span_a,
  input  logic [REG_W-1:0]  base_b,
  input  logic [SPAN_W-1:0] span_b,
  output logic              hit
);
  assign hit = enable && grp_overlap(base_a, span_a, base_b, span_b);
endmodule

// File: rtl/vgrp_rule_eval.sv
module vgrp_rule_eval
  import vgrp_pkg::*;
(
  input  rule_plan_t          plan,
  input  logic [REG_W-1:0]    dst_reg,
  input  logic [REG_W-1:0]    src2_reg,
  input  logic [REG_W-1:0]    src1_reg,
  input  logic                src1_is_vec,
  input  logic                masked,
  input  logic [LMUL_W-1:0]   lmul_log2,
  input  logic [WCODE_W-1:0]  sew_code,
  input  logic [WCODE_W-1:0]  elen_code,
  input  logic [NF_W-1:0]     seg_fields,
  output logic [NRULES-1:0]   fail
);
  // named internal events
  logic multi_grp;
  logic group_rules_on;
  logic lmul_too_big;
  logic width_too_big;
  logic v0_hit;
  logic seg_hit;
  logic [NOPS-1:0] align_fail;
  logic [1:0]      ovl_fail;

  assign multi_grp      = lmul_log2 != '0;
  assign group_rules_on = !(plan.gate_multi && !multi_grp);
  assign lmul_too_big   = plan.chk_limits && (lmul_log2 > LMUL_W'(LMUL_MAX_WIDE));
  assign width_too_big  = plan.chk_limits && (sew_code >= elen_code);

  logic [REG_W-1:0] op_reg [NOPS];
  gsz_e             op_sz  [NOPS];
  logic             op_on  [NOPS];

  assign op_reg[0] = dst_reg;
  assign op_reg[1] = src2_reg;
  assign op_reg[2] = src1_reg;
  assign op_sz[0]  = plan.dst_al;
  assign op_sz[1]  = plan.src2_al;
  assign op_sz[2]  = plan.src1_al;
  assign op_on[0]  = group_rules_on;
  assign op_on[1]  = group_rules_on;
  assign op_on[2]  = group_rules_on && src1_is_vec;

  for (genvar g = 0; g < NOPS; g++) begin : g_align
    assign align_fail[g] = op_on[g] && grp_misaligned(op_reg[g], grp_span(op_sz[g], lmul_log2));
  end

  logic [SPAN_W-1:0] dst_span;
  assign dst_span = grp_span(plan.ovl_dst, lmul_log2);

  logic [REG_W-1:0]  src_base [2];
  logic [SPAN_W-1:0] src_span [2];
  logic              src_on   [2];
  assign src_base[0] = src2_reg;
  assign src_base[1] = src1_reg;
  assign src_span[0] = grp_span(plan.ovl_src2, lmul_log2);
  assign src_span[1] = grp_span(plan.ovl_src1, lmul_log2);
  assign src_on[0]   = group_rules_on;
  assign src_on[1]   = group_rules_on && src1_is_vec;

  for (genvar s = 0; s < 2; s++) begin : g_ovl
    vgrp_overlap_unit u_ovl (
      .enable (src_on[s]),
      .base_a (dst_reg),
      .span_a (dst_span),
      .base_b (src_base[s]),
      .span_b (src_span[s]),
      .hit    (ovl_fail[s])
    );
  end

  assign v0_hit  = masked && (dst_reg == '0) &&
                   ((plan.v0 == V0_ALWAYS) || ((plan.v0 == V0_MULTI) && multi_grp));
  assign seg_hit = plan.chk_seg && seg_overflow(seg_fields, lmul_log2);

  always_comb begin
    fail             = '0;
    fail[RULE_LMUL]  = lmul_too_big;
    fail[RULE_WIDTH] = width_too_big;
    fail[RULE_DALN]  = align_fail[0];
    fail[RULE_S2ALN] = align_fail[1];
    fail[RULE_S1ALN] = align_fail[2];
    fail[RULE_V0]    = v0_hit;
    fail[RULE_OV2]   = ovl_fail[0];
    fail[RULE_OV1]   = ovl_fail[1];
    fail[RULE_SEG]   = seg_hit;
  end
endmodule

// File: rtl/vgrp_legality_check.sv
module vgrp_legality_check
  import vgrp_pkg::*;
(
  input  logic [4:0] dst_reg,
  input  logic [4:0] src2_reg,
  input  logic [4:0] src1_reg,
  input  logic       src1_is_vec,
  input  logic       masked,
  input  logic [1:0] lmul_log2,
  input  logic [1:0] sew_code,
  input  logic [1:0] elen_code,
  input  logic [2:0] seg_fields,
  input  logic [2:0] op_class,
  output logic       illegal,
  output logic [8:0] rule_fail
);
  rule_plan_t        plan;
  logic [NRULES-1:0] fail_vec;

  vgrp_class_plan u_plan (
    .cls  (opclass_e'(op_class)),
    .plan (plan)
  );

  vgrp_rule_eval u_eval (
    .plan        (plan),
    .dst_reg     (dst_reg),
    .src2_reg    (src2_reg),
    .src1_reg    (src1_reg),
    .src1_is_vec (src1_is_vec),
    .masked      (masked),
    .lmul_log2   (lmul_log2),
    .sew_code    (sew_code),
    .elen_code   (elen_code),
    .seg_fields  (seg_fields),
    .fail        (fail_vec)
  );

  assign rule_fail = fail_vec;
  assign illegal   = |fail_vec;
endmodule

// File: rtl/vgrp_legality_check_sva.sv
module vgrp_legality_check_sva (
  input logic [4:0] dst_reg,
  input logic [4:0] src2_reg,
  input logic       masked,
  input logic [1:0] lmul_log2,
  input logic [2:0] seg_fields,
  input logic [2:0] op_class,
  input logic       illegal,
  input logic [8:0] rule_fail
);
  always_comb begin
    // R1: illegal follows the rule flags in both directions
    p_flag_agree_r1: assert (illegal == (rule_fail != 9'd0))
      else $error("illegal disagrees with rule flags");
    // R2: limit bits stay low outside the double-width classes
    p_limits_scope_r2: assert (!(op_class == 3'd0 || op_class == 3'd4 || op_class == 3'd5 ||
                                 op_class == 3'd7) || rule_fail[1:0] == 2'b00)
      else $error("limit rule raised in wrong class");
    // R3: masked single-width write to register 0 with a multi-register group
    p_single_v0_r3: assert (!(op_class == 3'd0 && masked && dst_reg == 5'd0 &&
                              lmul_log2 != 2'd0) || illegal)
      else $error("masked v0 write accepted");
    // R4: odd destination of a widening op is never a multiple of 2L
    p_wide_dst_r4: assert (!(op_class == 3'd1 && dst_reg[0]) || rule_fail[2])
      else $error("odd widening destination accepted");
    // R6: odd narrowing source is never a multiple of 2L
    p_narrow_src_r6: assert (!(op_class == 3'd3 && src2_reg[0]) || rule_fail[3])
      else $error("odd narrowing source accepted");
    // R7: mask-producing class has no rule at group size 1
    p_mask_single_r7: assert (!(op_class == 3'd4 && lmul_log2 == 2'd0) || !illegal)
      else $error("mask class rejected at group size 1");
    // R8: reductions only ever raise the second source alignment bit
    p_reduce_bits_r8: assert (op_class != 3'd5 || (rule_fail & 9'h1F7) == 9'd0)
      else $error("reduction raised foreign rule");
    // R9: eight fields with any group above 1 exceed the budget
    p_seg_budget_r9: assert (!(op_class == 3'd7 && seg_fields == 3'd7 && lmul_log2 != 2'd0) ||
                             rule_fail[8])
      else $error("segment budget not enforced");
  end
endmodule

bind vgrp_legality_check vgrp_legality_check_sva u_sva (
  .dst_reg    (dst_reg),
  .src2_reg   (src2_reg),
  .masked     (masked),
  .lmul_log2  (lmul_log2),
  .seg_fields (seg_fields),
  .op_class   (op_class),
  .illegal    (illegal),
  .rule_fail  (rule_fail)
);

// File: tb/vgrp_legality_check_test.sv
module vgrp_legality_check_test;
  logic       clk = 1'b0;
  logic [4:0] dst_reg, src2_reg, src1_reg;
  logic       src1_is_vec, masked;
  logic [1:0] lmul_log2, sew_code, elen_code;
  logic [2:0] seg_fields, op_class;
  logic       illegal;
  logic [8:0] rule_fail;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vgrp_legality_check uut (
    .dst_reg(dst_reg), .src2_reg(src2_reg), .src1_reg(src1_reg),
    .src1_is_vec(src1_is_vec), .masked(masked), .lmul_log2(lmul_log2),
    .sew_code(sew_code), .elen_code(elen_code), .seg_fields(seg_fields),
    .op_class(op_class), .illegal(illegal), .rule_fail(rule_fail)
  );

  // membership test, register by register
  function automatic bit ref_overlap(int a, int sa, int b, int sb);
    for (int k = 0; k < 64; k++)
      if (k >= a && k < a + sa && k >= b && k < b + sb) return 1'b1;
    return 1'b0;
  endfunction

  // behavioural model of all rules (bit order per R11)
  function automatic logic [8:0] ref_rules(int cls, int d, int s2, int s1, bit vec, bit msk,
                                           int lm, int sew, int elen, int nf);
    logic [8:0] r = '0;
    int l = 1 << lm;
    bit lim = (cls == 1 || cls == 2 || cls == 3 || cls == 6);
    if (lim) begin
      if (l > 4) r[0] = 1'b1;
      if (2 * (8 << sew) > (8 << elen)) r[1] = 1'b1;
    end
    case (cls)
      0: if (l > 1) begin
        if (d % l != 0) r[2] = 1'b1;
        if (s2 % l != 0) r[3] = 1'b1;
        if (vec && s1 % l != 0) r[4] = 1'b1;
        if (msk && d == 0) r[5] = 1'b1;
      end
      1: begin
        if (d % (2 * l) != 0) r[2] = 1'b1;
        if (msk && d == 0) r[5] = 1'b1;
        if (s2 % l != 0) r[3] = 1'b1;
        if (ref_overlap(d, 2 * l, s2, l)) r[6] = 1'b1;
        if (vec) begin
          if (s1 % l != 0) r[4] = 1'b1;
          if (ref_overlap(d, 2 * l, s1, l)) r[7] = 1'b1;
        end
      end
      2: begin
        if (d % (2 * l) != 0) r[2] = 1'b1;
        if (msk && d == 0) r[5] = 1'b1;
        if (s2 % (2 * l) != 0) r[3] = 1'b1;
        if (vec) begin
          if (s1 % l != 0) r[4] = 1'b1;
          if (ref_overlap(d, 2 * l, s1, l)) r[7] = 1'b1;
        end
      end
      3: begin
        if (s2 % (2 * l) != 0) r[3] = 1'b1;
        if (d % l != 0) r[2] = 1'b1;
        if (ref_overlap(d, l, s2, 2 * l)) r[6] = 1'b1;
        if (msk && l > 1 && d == 0) r[5] = 1'b1;
        if (vec && s1 % l != 0) r[4] = 1'b1;
      end
      4: if (l > 1) begin
        if (ref_overlap(d, 1, s2, l)) r[6] = 1'b1;
        if (s2 % l != 0) r[3] = 1'b1;
        if (vec) begin
          if (ref_overlap(d, 1, s1, l)) r[7] = 1'b1;
          if (s1 % l != 0) r[4] = 1'b1;
        end
      end
      5, 6: if (s2 % l != 0) r[3] = 1'b1;
      default: begin
        if (l > 1) begin
          if (d % l != 0) r[2] = 1'b1;
          if (msk && d == 0) r[5] = 1'b1;
        end
        if ((nf + 1) * l > 8) r[8] = 1'b1;
      end
    endcase
    return r;
  endfunction

  function automatic string cls_tag(int cls);
    case (cls)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5, 6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(int cls, int d, int s2, int s1, bit vec, bit msk,
                       int lm, int sew, int elen, int nf);
    op_class = 3'(cls); dst_reg = 5'(d); src2_reg = 5'(s2); src1_reg = 5'(s1);
    src1_is_vec = vec; masked = msk; lmul_log2 = 2'(lm);
    sew_code = 2'(sew); elen_code = 2'(elen); seg_fields = 3'(nf);
    #1;
  endtask

  task automatic check(string req, logic [8:0] exp);
    n_checks++;
    if (rule_fail !== exp || illegal !== (|exp)) begin
      n_errors++;
      $display("FAIL %s cls=%0d d=%0d s2=%0d s1=%0d lm=%0d: flags=%b ill=%b expected flags=%b ill=%b",
               req, op_class, dst_reg, src2_reg, src1_reg, lmul_log2,
               rule_fail, illegal, exp, |exp);
    end
  endtask

  // R1: quiet inputs give a legal result
  task automatic t_idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 3, 0);
    check("R1 idle", 9'd0);
  endtask

  // R3..R10: full sweep of one class, every group size and register pair
  task automatic t_sweep(int cls);
    for (int lm = 0; lm < 4; lm++)
      for (int d = 0; d < 32; d++)
        for (int s2 = 0; s2 < 32; s2++) begin
          int  s1   = (d + 5 * s2 + lm) % 32;
          bit  vec  = bit'((s2 ^ (d >> 1)) & 1);
          bit  msk  = bit'((d + s2) & 1) | (d == 0);
          int  sew  = (s2 >> 3) & 3;
          int  elen = (d >> 3) & 3;
          int  nf   = (d + s2) & 7;
          drive(cls, d, s2, s1, vec, msk, lm, sew, elen, nf);
          check({cls_tag(cls), "/R10/R11 sweep"},
                ref_rules(cls, d, s2, s1, vec, msk, lm, sew, elen, nf));
        end
  endtask

  // R2: all width and multiplier codes for every class, aligned registers
  task automatic t_limits();
    for (int cls = 0; cls < 8; cls++)
      for (int lm = 0; lm < 4; lm++)
        for (int sew = 0; sew < 4; sew++)
          for (int elen = 0; elen < 4; elen++) begin
            drive(cls, 16, 0, 0, 0, 0, lm, sew, elen, 0);
            check("R2 limits", ref_rules(cls, 16, 0, 0, 0, 0, lm, sew, elen, 0));
          end
  endtask

  // R9: segment budget for every field count and group size
  task automatic t_segments();
    for (int lm = 0; lm < 4; lm++)
      for (int nf = 0; nf < 8; nf++) begin
        drive(7, 8, 3, 5, 1, 0, lm, 0, 3, nf);
        check("R9 segment", ((nf + 1) * (1 << lm) > 8) ? 9'h100 : 9'h000);
      end
  endtask

  // hand-computed corners
  task automatic t_corners();
    drive(4, 3, 3, 3, 1, 1, 0, 0, 3, 0);
    check("R7 group size 1 passes", 9'h000);
    drive(4, 5, 4, 0, 0, 0, 1, 0, 3, 0);
    check("R7 dest inside source group", 9'h040);
    drive(1, 4, 6, 0, 0, 0, 1, 0, 3, 0);
    check("R4 partial overlap at group top", 9'h040);
    drive(1, 16, 8, 9, 1, 1, 3, 0, 3, 0);
    check("R4 group size 8", 9'h091);
    drive(3, 4, 0, 0, 0, 0, 2, 0, 3, 0);
    check("R6 narrow overlap", 9'h040);
    drive(3, 0, 8, 0, 0, 1, 0, 0, 3, 0);
    check("R6 masked v0 at group size 1 passes", 9'h000);
    drive(2, 0, 4, 2, 1, 1, 1, 0, 3, 0);
    check("R5 masked v0 and first source overlap", 9'h0A0);
    drive(2, 4, 2, 7, 0, 0, 1, 0, 3, 0);
    check("R10 scalar first source ignored", 9'h008);
    drive(0, 0, 1, 3, 1, 1, 0, 3, 3, 0);
    check("R3 group size 1 passes", 9'h000);
    drive(5, 3, 3, 3, 1, 1, 3, 3, 0, 7);
    check("R8 reduction misaligned source only", 9'h008);
  endtask

  initial begin
    t_idle();
    t_corners();
    t_limits();
    t_segments();
    for (int c = 0; c < 8; c++) t_sweep(c);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule